// File: doc/BRIEF.md
# APB Command Packet Queue for a Display Link Host

This block sits between an APB register bus and the packet engine of a serial display link host. Software sends a command packet in two steps. It first writes the bytes of the packet body, one 32-bit word at a time, into a payload register. It then writes the packet header. Writing the header is the trigger that queues the packet for transmission. The link side takes the queued header first, then exactly as many payload words as the header calls for, each through its own valid/ready channel. Read responses from the display come back through a third channel and are popped by reading the payload register.

The block holds three FIFOs: headers, outgoing payload words and incoming readback words. A mode register gates release to the link. While neither the video nor the command mode bit is set, no header is offered, so the queues fill up and then overflow. A status register shows the empty and full flags of every queue. It also holds sticky overflow flags that software clears by writing ones.

Back-pressure rules:
- A valid output holds its data stable until ready is seen high at a clock edge.
- The block never offers a header and a payload word in the same cycle.
- The readback channel accepts a word only when its ready is high, and ready is low only while the readback queue is full.

Top module: `apb_cmd_pkt_if`

## Requirements
- R1: A write to offset 0x0 queues bits [23:0] as a header: bits [7:0] are the data type and bits [23:8] are two data bytes. Headers leave on `hdr_data` in write order.
- R2: A write to offset 0x4 queues a 32-bit payload word. Words leave on `pld_data` unchanged and in write order, so byte lane [7:0] carries the first byte to be sent.
- R3: A header whose data type has low nibble 0x9 is a long packet. Its bits [23:8] are a byte count N, and after the header handshake exactly ceil(N/4) payload words are offered. Any other header, and a long header with N = 0, is followed by no payload word.
- R4: The mode register at offset 0x8 has bit 0 for video and bit 1 for command, and resets to 0. While both bits are 0, `hdr_valid` stays low. Either bit alone releases queued headers.
- R5: Once `hdr_valid` or `pld_valid` is high without its ready, it stays high with stable data in the next cycle. `hdr_valid` and `pld_valid` are never high together.
- R6: A read of offset 0x4 pops the readback queue and returns its words in arrival order. `rdback_ready` is low exactly while that queue is full.
- R7: A read of offset 0x4 while the readback queue is empty returns 0 and raises `pslverr` in that access phase.
- R8: The status register at offset 0xC is read-only with these bits:
  - [0] header queue empty, [1] header queue full
  - [2] payload queue empty, [3] payload queue full
  - [4] readback queue empty, [5] readback queue full
  - [6] header overflow, [7] payload overflow
- R9: A write to a full header or payload queue is dropped and sets that queue's overflow bit. The bit stays set until a status write with a one in its position.
- R10: After reset all queues are empty, status reads 0x15 and no link valid is high. `pready` is always high, so every access takes one setup and one access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and link sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address, bits [3:2] decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Error on read of empty readback queue |
| hdr_valid | output | 1 | Header offered to link |
| hdr_ready | input | 1 | Link accepts header |
| hdr_data | output | 24 | Header: type [7:0], data bytes [23:8] |
| pld_valid | output | 1 | Payload word offered to link |
| pld_ready | input | 1 | Link accepts payload word |
| pld_data | output | 32 | Payload word, first byte in [7:0] |
| rdback_valid | input | 1 | Link presents a readback word |
| rdback_ready | output | 1 | Readback queue can accept |
| rdback_data | input | 32 | Readback word |

## Verification
A wrong queue pointer or count shows at the link ports within one handshake: a header or payload word arrives out of order, is repeated, or never arrives. A wrong occupancy count also shows in the status flags as soon as the queue is read. A wrong payload word count in the sequencer shows within a few cycles after the header: a spare `pld_valid` appears, or the next `hdr_valid` is blocked. Overflow and gating faults show in the status register on the next read, and as missing or extra headers once the mode is enabled.

// File: rtl/cmdpkt_pkg.sv
package cmdpkt_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HDR_W  = 24;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic [1:0] {
    REG_HDR  = 2'd0,
    REG_PLD  = 2'd1,
    REG_MODE = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic {
    EG_HDR = 1'b0,
    EG_PLD = 1'b1
  } eg_state_e;

  function automatic logic is_long(input logic [7:0] dtype);
    return dtype[3:0] == 4'h9;
  endfunction

  function automatic logic [CNT_W-1:0] words_for(input logic [CNT_W-1:0] nbytes);
    logic [CNT_W:0] sum;
    sum = {1'b0, nbytes} + (CNT_W+1)'(3);
    return sum[CNT_W:2];
  endfunction
endpackage

// File: rtl/cmdpkt_fifo.sv
module cmdpkt_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cmdpkt_egress.sv
module cmdpkt_egress
  import cmdpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_on,
  input  logic              hq_empty,
  input  logic [HDR_W-1:0]  hq_head,
  output logic              hq_pop,
  input  logic              pq_empty,
  input  logic [WORD_W-1:0] pq_head,
  output logic              pq_pop,
  output logic              hdr_valid,
  input  logic              hdr_ready,
  output logic [HDR_W-1:0]  hdr_data,
  output logic              pld_valid,
  input  logic              pld_ready,
  output logic [WORD_W-1:0] pld_data
);
  eg_state_e        st_q;
  logic [CNT_W-1:0] left_q;
  logic             hold_q;
  logic [CNT_W-1:0] need;

  assign hdr_valid = (st_q == EG_HDR) && !hq_empty && (mode_on || hold_q);
  assign hdr_data  = hq_head;
  assign hq_pop    = hdr_valid && hdr_ready;
  assign pld_valid = (st_q == EG_PLD) && !pq_empty;
  assign pld_data  = pq_head;
  assign pq_pop    = pld_valid && pld_ready;
  assign need      = is_long(hq_head[7:0]) ? words_for(hq_head[HDR_W-1:8]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EG_HDR;
      left_q <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= hdr_valid && !hdr_ready;
      case (st_q)
        EG_HDR: if (hq_pop && need != '0) begin
          st_q   <= EG_PLD;
          left_q <= need;
        end
        EG_PLD: if (pq_pop) begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) st_q <= EG_HDR;
        end
        default: st_q <= EG_HDR;
      endcase
    end
  end
endmodule

// File: rtl/apb_cmd_pkt_if.sv
module apb_cmd_pkt_if
  import cmdpkt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CMD_DEPTH = 4,
  parameter int WPL_DEPTH = 8,
  parameter int RPL_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              hdr_valid,
  input  logic              hdr_ready,
  output logic [23:0]       hdr_data,
  output logic              pld_valid,
  input  logic              pld_ready,
  output logic [31:0]       pld_data,
  input  logic              rdback_valid,
  output logic              rdback_ready,
  input  logic [31:0]       rdback_data
);
  reg_sel_e          sel;
  logic              wr_acc, rd_acc;
  logic [1:0]        mode_q;
  logic [1:0]        ovf_q;
  logic              cmd_push, cmd_pop, cmd_empty, cmd_full;
  logic [HDR_W-1:0]  cmd_head;
  logic              wpl_push, wpl_pop, wpl_empty, wpl_full;
  logic [WORD_W-1:0] wpl_head;
  logic              rpl_push, rpl_pop, rpl_empty, rpl_full;
  logic [WORD_W-1:0] rpl_head;
  logic [7:0]        status;

  assign sel    = reg_sel_e'(paddr[3:2]);
  assign wr_acc = psel && penable && pwrite;
  assign rd_acc = psel && penable && !pwrite;
  assign pready = 1'b1;

  assign cmd_push     = wr_acc && (sel == REG_HDR);
  assign wpl_push     = wr_acc && (sel == REG_PLD);
  assign rpl_push     = rdback_valid && rdback_ready;
  assign rpl_pop      = rd_acc && (sel == REG_PLD) && !rpl_empty;
  assign rdback_ready = !rpl_full;

  cmdpkt_fifo #(.W(HDR_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(pwdata[HDR_W-1:0]),
    .pop(cmd_pop), .dout(cmd_head), .empty(cmd_empty), .full(cmd_full));

  cmdpkt_fifo #(.W(WORD_W), .DEPTH(WPL_DEPTH)) u_wplq (
    .clk(clk), .rst_n(rst_n), .push(wpl_push), .din(pwdata),
    .pop(wpl_pop), .dout(wpl_head), .empty(wpl_empty), .full(wpl_full));

  cmdpkt_fifo #(.W(WORD_W), .DEPTH(RPL_DEPTH)) u_rplq (
    .clk(clk), .rst_n(rst_n), .push(rpl_push), .din(rdback_data),
    .pop(rpl_pop), .dout(rpl_head), .empty(rpl_empty), .full(rpl_full));

  cmdpkt_egress u_eg (
    .clk(clk), .rst_n(rst_n), .mode_on(|mode_q),
    .hq_empty(cmd_empty), .hq_head(cmd_head), .hq_pop(cmd_pop),
    .pq_empty(wpl_empty), .pq_head(wpl_head), .pq_pop(wpl_pop),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
    .pld_valid(pld_valid), .pld_ready(pld_ready), .pld_data(pld_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      ovf_q  <= 2'b00;
    end else begin
      if (wr_acc && sel == REG_MODE) mode_q <= pwdata[1:0];
      for (int i = 0; i < 2; i++) begin
        if (wr_acc && sel == REG_STAT && pwdata[6+i]) ovf_q[i] <= 1'b0;
      end
      if (cmd_push && cmd_full) ovf_q[0] <= 1'b1;
      if (wpl_push && wpl_full) ovf_q[1] <= 1'b1;
    end
  end

  assign status = {ovf_q[1], ovf_q[0], rpl_full, rpl_empty,
                   wpl_full, wpl_empty, cmd_full, cmd_empty};

  always_comb begin
    prdata  = '0;
    pslverr = 1'b0;
    if (rd_acc) begin
      case (sel)
        REG_PLD: begin
          if (rpl_empty) pslverr = 1'b1;
          else           prdata  = rpl_head;
        end
        REG_MODE: prdata = {30'd0, mode_q};
        REG_STAT: prdata = {24'd0, status};
        default:  prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/apb_cmd_pkt_if_chk.sv
module apb_cmd_pkt_if_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       prdata,
  input logic              pslverr,
  input logic [1:0]        mode_q,
  input logic              hdr_valid,
  input logic              hdr_ready,
  input logic [23:0]       hdr_data,
  input logic              pld_valid,
  input logic              pld_ready,
  input logic [31:0]       pld_data
);
  p_hdr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data));

  p_pld_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pld_valid && !pld_ready |=> pld_valid && $stable(pld_data));

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_valid && pld_valid));

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_valid) |-> mode_q != 2'b00);

  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> prdata == 32'd0 && psel && penable && !pwrite && paddr[3:2] == 2'd1);
endmodule

bind apb_cmd_pkt_if apb_cmd_pkt_if_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pslverr(pslverr), .mode_q(mode_q),
  .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
  .pld_valid(pld_valid), .pld_ready(pld_ready), .pld_data(pld_data));

// File: tb/sim_apb_cmd_pkt_if.sv
`timescale 1ns/1ps
module sim_apb_cmd_pkt_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        hdr_valid, hdr_ready = 1'b0;
  logic [23:0] hdr_data;
  logic        pld_valid, pld_ready = 1'b0;
  logic [31:0] pld_data;
  logic        rdback_valid = 1'b0, rdback_ready;
  logic [31:0] rdback_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  apb_cmd_pkt_if u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .pld_valid(pld_valid), .pld_ready(pld_ready),
    .pld_data(pld_data), .rdback_valid(rdback_valid),
    .rdback_ready(rdback_ready), .rdback_data(rdback_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [3:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata; e = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_stat(input string req, input logic [31:0] exp);
    logic [31:0] d; logic e;
    apb_rd(4'hC, d, e);
    chk(req, d, exp);
  endtask

  task automatic get_hdr(input string req, input logic [23:0] exp);
    int n = 0;
    @(negedge clk);
    while (!hdr_valid && n < 40) begin @(negedge clk); n++; end
    chk({req, " hdr_valid"}, 32'(hdr_valid), 32'd1);
    chk({req, " hdr_data"}, 32'(hdr_data), 32'(exp));
    hdr_ready = 1'b1;
    @(negedge clk);
    hdr_ready = 1'b0;
  endtask

  task automatic get_pld(input string req, input logic [31:0] exp, input int stall);
    int n = 0;
    while (!pld_valid && n < 40) begin @(negedge clk); n++; end
    chk({req, " pld_valid"}, 32'(pld_valid), 32'd1);
    chk({req, " pld_data"}, pld_data, exp);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R5 held valid", 32'(pld_valid), 32'd1);
      chk("R5 stable data", pld_data, exp);
    end
    pld_ready = 1'b1;
    @(negedge clk);
    pld_ready = 1'b0;
  endtask

  task automatic quiet(input string req, input int cyc);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (hdr_valid || pld_valid) seen = 1'b1;
    end
    chk(req, 32'(seen), 32'd0);
  endtask

  task automatic push_rd(input logic [31:0] d);
    @(negedge clk);
    rdback_valid = 1'b1; rdback_data = d;
    @(negedge clk);
    rdback_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    chk("R10 hdr_valid at reset", 32'(hdr_valid), 32'd0);
    chk("R10 pld_valid at reset", 32'(pld_valid), 32'd0);
    chk("R10 pready", 32'(pready), 32'd1);
    chk("R6 rdback_ready at reset", 32'(rdback_ready), 32'd1);
    rd_stat("R10 status at reset", 32'h15);
    apb_rd(4'h8, d, e);
    chk("R4 mode reset value", d, 32'd0);
  endtask

  task automatic t_gate;
    apb_wr(4'h0, 32'h00AB05);
    apb_wr(4'h0, 32'h00CD15);
    apb_wr(4'h0, 32'h001105);
    apb_wr(4'h0, 32'h002215);
    apb_wr(4'h0, 32'h00FF05);
    quiet("R4 no header while mode off", 8);
    rd_stat("R8 R9 header full with overflow", 32'h56);
    apb_wr(4'hC, 32'h40);
    rd_stat("R9 overflow cleared by one", 32'h16);
    apb_wr(4'h8, 32'h2);
    get_hdr("R1 first", 24'h00AB05);
    get_hdr("R1 second", 24'h00CD15);
    get_hdr("R1 third", 24'h001105);
    get_hdr("R1 fourth", 24'h002215);
    quiet("R9 dropped header absent", 6);
    rd_stat("R8 queues empty", 32'h15);
  endtask

  task automatic t_long;
    apb_wr(4'h4, 32'h44332211);
    apb_wr(4'h4, 32'h88776655);
    apb_wr(4'h4, 32'h00CCBBAA);
    apb_wr(4'h0, 32'h000A29);
    get_hdr("R3 long hdr", 24'h000A29);
    get_pld("R2 word0", 32'h44332211, 3);
    get_pld("R2 word1", 32'h88776655, 0);
    get_pld("R2 word2", 32'h00CCBBAA, 1);
    quiet("R3 exactly three words", 5);
    apb_wr(4'h0, 32'h000039);
    get_hdr("R3 zero-length long", 24'h000039);
    quiet("R3 zero-length has no payload", 5);
    apb_wr(4'h4, 32'hA5A5A5A5);
    apb_wr(4'h0, 32'h001205);
    get_hdr("R3 short hdr", 24'h001205);
    quiet("R3 short has no payload", 5);
    apb_wr(4'h0, 32'h000429);
    get_hdr("R3 four-byte long", 24'h000429);
    get_pld("R3 single word", 32'hA5A5A5A5, 0);
    quiet("R3 one word only", 4);
  endtask

  task automatic t_video;
    apb_wr(4'h8, 32'h1);
    apb_wr(4'h0, 32'h003405);
    get_hdr("R4 video mode releases", 24'h003405);
  endtask

  task automatic t_wpl_ovf;
    apb_wr(4'h8, 32'h0);
    for (int i = 0; i < 8; i++) apb_wr(4'h4, 32'h1000 + 32'(i));
    apb_wr(4'h4, 32'hDEAD);
    rd_stat("R9 payload full with overflow", 32'h99);
    apb_wr(4'hC, 32'h80);
    rd_stat("R9 payload overflow cleared", 32'h19);
    apb_wr(4'h8, 32'h2);
    apb_wr(4'h0, 32'h002029);
    get_hdr("R3 32-byte long", 24'h002029);
    for (int i = 0; i < 8; i++) get_pld("R9 kept words", 32'h1000 + 32'(i), 0);
    quiet("R9 dropped word absent", 5);
    rd_stat("R8 all empty again", 32'h15);
  endtask

  task automatic t_rdback;
    logic [31:0] d; logic e;
    for (int i = 0; i < 4; i++) push_rd(32'hB000 + 32'(i));
    chk("R6 ready low when full", 32'(rdback_ready), 32'd0);
    rd_stat("R8 readback full", 32'h25);
    for (int i = 0; i < 4; i++) begin
      apb_rd(4'h4, d, e);
      chk("R6 readback order", d, 32'hB000 + 32'(i));
      chk("R6 no error", 32'(e), 32'd0);
    end
    apb_rd(4'h4, d, e);
    chk("R7 empty read data", d, 32'd0);
    chk("R7 empty read pslverr", 32'(e), 32'd1);
    rd_stat("R8 readback empty", 32'h15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_long();
    t_video();
    t_wpl_ovf();
    t_rdback();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule